// File: doc/BRIEF.md
# Linear Burst Read Sequencer for a Double-Data-Rate Octal Memory Bus

This block is the host side of a read-only path to an octal double-data-rate memory device. A client hands it a 16-bit-word address and a burst length in words. The block pulls the chip select low, respects a setup interval, and shifts out a six-byte command-address header. It then waits a fixed initial latency and collects one 16-bit word per bus clock. Each word goes to the client with a valid flag, and the final word of the burst also carries a last flag.

The bus clock is produced from a system clock that runs at twice its rate, so every system cycle is one bus-clock edge. Some start offsets within a 16-word page need one extra bus clock before the data can continue. The block inserts that stall clock at the right place in the stream. When the burst ends it reports how many bus clocks the transaction used. It also keeps the chip select high for a minimum time before it accepts the next request.

The request port uses valid/ready. A request is taken on a cycle where both are high, and the client must hold its address and length steady until then. Ready stays low while a transaction runs and while the chip-select-high interval is still counting. The word output has no ready input, because the device cannot be paused here. The client must take every beat in the cycle it is valid.

Top module: `hbrd_seq`

## Requirements
- R1: `req_ready` is high only when no transaction is active, the chip select is high, and at least `CSHI_CYC` system cycles have passed since the chip select last rose. A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high.
- R2: An accepted request with `req_len` equal to zero starts no transaction. It raises `req_err` for exactly one cycle and leaves `cs_n` high.
- R3: The header is six bytes, sent on six consecutive bus-clock edges with the most significant byte first and `dq_oe` high. The bit layout is: bit 47 = 1 (read), bit 46 = 0 (memory space), bit 45 = 1 (linear burst), bits 44:16 = address bits 31:3, bits 15:3 = 0, bits 2:0 = address bits 2:0.
- R4: The header takes three bus clocks. It is followed by `LAT_CLK-1` idle bus clocks. Data is sampled from the edges of bus clocks number `LAT_CLK+3` onward, counting the first header clock as number 1.
- R5: Let the start address have low nibble 0x7 or 0xF. Set L = 16 minus that nibble (9 words or 1 word). If the length is greater than L, one stall bus clock is inserted after the first L words and the data is not sampled during it. No other start offset, and no length of L or less, gets a stall.
- R6: Each word is built from two bytes, with the byte on the first edge of the pair as the upper half. Exactly `req_len` words are presented with `rd_valid`. `rd_last` is high only on the final word. Word n carries the device data for address start+n.
- R7: When the chip select deasserts, `txn_done` pulses for one cycle. At that moment `txn_clks` equals `LAT_CLK + 2 + req_len + stall`, where stall is 1 or 0. With `LAT_CLK` = 10, a 2-word read counts 14.
- R8: `bus_ck` rests low and does not toggle while `cs_n` is high. `bus_ck_n` is always its complement. At least `CSS_CYC` system cycles pass between the fall of `cs_n` and the first `bus_ck` edge.
- R9: Between two transactions, `cs_n` stays high for at least `CSHI_CYC` system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bus-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Start address in 16-bit words |
| req_len | input | LEN_W | Burst length in words |
| req_err | output | 1 | One-cycle pulse for a zero-length request |
| cs_n | output | 1 | Active-low chip select |
| bus_ck | output | 1 | Bus clock |
| bus_ck_n | output | 1 | Complement of the bus clock |
| dq_o | output | 8 | Header byte driven to the bus |
| dq_oe | output | 1 | Output enable for `dq_o` |
| dq_i | input | 8 | Byte returned by the device |
| rd_valid | output | 1 | Word valid |
| rd_data | output | 16 | Captured word |
| rd_last | output | 1 | Final word of the burst |
| txn_done | output | 1 | Pulse when the chip select deasserts |
| txn_clks | output | CLK_W | Bus clocks used by the last transaction |

## Verification
A device model in the bench decodes the header it receives. It then returns address-dependent data on the exact edges the requirements name, and it skips a stall clock whenever the start offset calls for one. This means a misplaced latency, a missing stall or a spurious stall shows up as wrong words, not only as a wrong clock count.

The tests cover five start patterns:
- a page-aligned 2-word read, which checks the 14-clock case;
- an offset 0x7 burst long enough to cross the page, where the stall falls after nine words;
- an offset 0xF burst, where the stall falls after a single word;
- an offset 0x7 burst of exactly nine words, which needs no stall;
- an offset 0x6 burst, which never stalls.

Beyond these, a zero-length request checks the rejection path. Two requests queued back to back check the chip-select-high gap and the setup interval.

// File: rtl/hbrd_pkg.sv
`timescale 1ns/1ps
package hbrd_pkg;
  localparam int ADDR_W = 32;
  localparam int CA_W   = 48;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CA, ST_LAT, ST_DATA, ST_STALL, ST_END
  } seq_st_e;

  // Header word: read, memory space, linear burst, split word address.
  function automatic logic [CA_W-1:0] build_ca(input logic [ADDR_W-1:0] wa);
    logic [CA_W-1:0] c;
    c        = '0;
    c[47]    = 1'b1;
    c[46]    = 1'b0;
    c[45]    = 1'b1;
    c[44:16] = wa[31:3];
    c[2:0]   = wa[2:0];
    return c;
  endfunction
endpackage

// File: rtl/hbrd_gap_timer.sv
`timescale 1ns/1ps
module hbrd_gap_timer #(
  parameter int HOLD_CYC = 2,
  parameter int W        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic gap_ok
);
  localparam logic [W-1:0] LIM = W'(HOLD_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= LIM;
    else if (!cs_n)      cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_ok = cs_n && (cnt_q >= LIM);
endmodule

// File: rtl/hbrd_word_cap.sv
`timescale 1ns/1ps
module hbrd_word_cap #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             cap,
  input  logic [7:0]       dq_i,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             rd_last
);
  logic             hi_q;
  logic [7:0]       hib_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 1'b1;
      hib_q    <= '0;
      left_q   <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      if (start) begin
        hi_q   <= 1'b1;
        left_q <= len;
      end else if (cap) begin
        if (hi_q) begin
          hib_q <= dq_i;
          hi_q  <= 1'b0;
        end else begin
          rd_data  <= {hib_q, dq_i};
          rd_valid <= 1'b1;
          rd_last  <= (left_q == LEN_W'(1));
          left_q   <= left_q - 1'b1;
          hi_q     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hbrd_seq.sv
`timescale 1ns/1ps
module hbrd_seq
  import hbrd_pkg::*;
#(
  parameter int LAT_CLK  = 10,
  parameter int LEN_W    = 12,
  parameter int CLK_W    = 16,
  parameter int CSHI_CYC = 2,
  parameter int CSS_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_err,
  output logic              cs_n,
  output logic              bus_ck,
  output logic              bus_ck_n,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  input  logic [7:0]        dq_i,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              rd_last,
  output logic              txn_done,
  output logic [CLK_W-1:0]  txn_clks
);
  localparam int LAT_HALF = 2 * (LAT_CLK - 1);
  localparam int HC_W     = $clog2(LAT_HALF + CSS_CYC + 8) + 1;
  localparam int DE_W     = LEN_W + 1;
  localparam int CA_EDGES = 6;

  seq_st_e          state_q;
  logic [HC_W-1:0]  hcnt_q;
  logic [CA_W-1:0]  ca_q;
  logic [LEN_W-1:0] len_q;
  logic [DE_W-1:0]  de_cnt_q, de_nx, stall_at_q;
  logic             stall_en_q;
  logic             ck_q, cs_n_q, dq_oe_q, cap_q, err_q, done_q;
  logic [7:0]       dq_o_q;
  logic [CLK_W-1:0] clk_cnt_q;
  logic             gap_ok, tog, accept, start_pulse;
  logic [4:0]       lead_w;

  assign tog    = (state_q == ST_CA) || (state_q == ST_LAT) ||
                  (state_q == ST_DATA) || (state_q == ST_STALL);
  assign req_ready   = (state_q == ST_IDLE) && gap_ok;
  assign accept      = req_valid && req_ready;
  assign start_pulse = accept && (req_len != '0);
  assign lead_w = 5'd16 - {1'b0, req_addr[3:0]};
  assign de_nx  = de_cnt_q + 1'b1;

  hbrd_gap_timer #(.HOLD_CYC(CSHI_CYC), .W(8)) gap_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n_q), .gap_ok(gap_ok)
  );

  hbrd_word_cap #(.LEN_W(LEN_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .len(req_len),
    .cap(cap_q), .dq_i(dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hcnt_q     <= '0;
      ca_q       <= '0;
      len_q      <= '0;
      de_cnt_q   <= '0;
      stall_at_q <= '0;
      stall_en_q <= 1'b0;
      ck_q       <= 1'b0;
      cs_n_q     <= 1'b1;
      dq_o_q     <= '0;
      dq_oe_q    <= 1'b0;
      cap_q      <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      clk_cnt_q  <= '0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      cap_q  <= 1'b0;
      if (tog) begin
        ck_q <= ~ck_q;
        if (!ck_q) clk_cnt_q <= clk_cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_len == '0) begin
              err_q <= 1'b1;
            end else begin
              cs_n_q     <= 1'b0;
              ca_q       <= build_ca(req_addr);
              len_q      <= req_len;
              stall_en_q <= (req_addr[2:0] == 3'b111) &&
                            ({{(LEN_W-5){1'b0}}, lead_w} < req_len);
              stall_at_q <= {{(LEN_W-5){1'b0}}, lead_w, 1'b0};
              de_cnt_q   <= '0;
              hcnt_q     <= '0;
              clk_cnt_q  <= '0;
              state_q    <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (hcnt_q >= HC_W'(CSS_CYC - 1)) begin
            hcnt_q  <= '0;
            state_q <= ST_CA;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_CA: begin
          dq_o_q  <= ca_q[CA_W-1 -: 8];
          ca_q    <= {ca_q[CA_W-9:0], 8'h00};
          dq_oe_q <= 1'b1;
          if (hcnt_q == HC_W'(CA_EDGES - 1)) begin
            hcnt_q  <= '0;
            state_q <= ST_LAT;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_LAT: begin
          dq_oe_q <= 1'b0;
          if (hcnt_q == HC_W'(LAT_HALF - 1)) begin
            hcnt_q  <= '0;
            state_q <= ST_DATA;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          cap_q    <= 1'b1;
          de_cnt_q <= de_nx;
          if (de_nx == {len_q, 1'b0}) begin
            state_q <= ST_END;
          end else if (stall_en_q && (de_nx == stall_at_q)) begin
            hcnt_q  <= '0;
            state_q <= ST_STALL;
          end
        end
        ST_STALL: begin
          if (hcnt_q == HC_W'(1)) begin
            hcnt_q  <= '0;
            state_q <= ST_DATA;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_END: begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n     = cs_n_q;
  assign bus_ck   = ck_q;
  assign bus_ck_n = ~ck_q;
  assign dq_o     = dq_o_q;
  assign dq_oe    = dq_oe_q;
  assign req_err  = err_q;
  assign txn_done = done_q;
  assign txn_clks = clk_cnt_q;
endmodule

// File: rtl/hbrd_seq_chk.sv
`timescale 1ns/1ps
module hbrd_seq_chk #(
  parameter int LAT_CLK  = 10,
  parameter int LEN_W    = 12,
  parameter int CLK_W    = 16,
  parameter int CSHI_CYC = 2,
  parameter int CSS_CYC  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             req_err,
  input logic             cs_n,
  input logic             bus_ck,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             txn_done,
  input logic [CLK_W-1:0] txn_clks
);
  logic [7:0] hi_cnt, lo_cnt;
  logic       seen_ck, ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= 8'(CSHI_CYC);
      lo_cnt  <= '0;
      seen_ck <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= bus_ck;
      if (cs_n) begin
        if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
        lo_cnt  <= '0;
        seen_ck <= 1'b0;
      end else begin
        hi_cnt <= '0;
        if (bus_ck != ck_prev) seen_ck <= 1'b1;
        else if (!seen_ck && lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (req_err && cs_n));

  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R7
  clk_count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> (txn_clks >= CLK_W'(LAT_CLK + 3)));

  // R8
  ck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !bus_ck);

  // R8
  ck_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !seen_ck && bus_ck != ck_prev) |-> (lo_cnt >= 8'(CSS_CYC)));

  // R9
  cs_high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 8'(CSHI_CYC)));
endmodule

bind hbrd_seq hbrd_seq_chk #(
  .LAT_CLK(LAT_CLK), .LEN_W(LEN_W), .CLK_W(CLK_W),
  .CSHI_CYC(CSHI_CYC), .CSS_CYC(CSS_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .req_err(req_err), .cs_n(cs_n), .bus_ck(bus_ck),
  .rd_valid(rd_valid), .rd_last(rd_last), .txn_done(txn_done),
  .txn_clks(txn_clks)
);

// File: tb/hbrd_seq_tb.sv
`timescale 1ns/1ps
module hbrd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 10;
  localparam int LEN_W      = 12;
  localparam int CLK_W      = 16;
  localparam int CSHI       = 2;
  localparam int CSS        = 1;
  localparam int DATA_E0    = 6 + 2 * (LAT - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_err, cs_n, bus_ck, bus_ck_n, dq_oe;
  logic [7:0]       dq_o;
  logic [7:0]       dq_i = '0;
  logic             rd_valid, rd_last, txn_done;
  logic [15:0]      rd_data;
  logic [CLK_W-1:0] txn_clks;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbrd_seq #(.LAT_CLK(LAT), .LEN_W(LEN_W), .CLK_W(CLK_W),
             .CSHI_CYC(CSHI), .CSS_CYC(CSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
    .cs_n(cs_n), .bus_ck(bus_ck), .bus_ck_n(bus_ck_n), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .txn_done(txn_done), .txn_clks(txn_clks)
  );

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  // ---------------- device model ----------------
  int          dev_e = 0;
  logic [47:0] ca_rx = '0;
  logic [31:0] dev_a = '0;
  int          dev_b = 0;
  bit          dev_st = 1'b0;

  always @(negedge cs_n) dev_e = 0;

  always @(bus_ck) begin : dev_blk
    int k;
    int j;
    logic [15:0] v;
    if (cs_n === 1'b0) begin
      #1;
      dev_e = dev_e + 1;
      if (dev_e <= 6) begin
        ca_rx = {ca_rx[39:0], dq_o};
        if (dev_e == 6) begin
          dev_a  = {ca_rx[44:16], ca_rx[2:0]};
          dev_st = (dev_a[2:0] == 3'b111);
          dev_b  = 16 - int'(dev_a[3:0]);
        end
      end else if (dev_e > DATA_E0) begin
        k = dev_e - DATA_E0 - 1;
        j = k;
        if (dev_st && k >= 2 * dev_b) j = (k < 2 * dev_b + 2) ? -1 : k - 2;
        if (j >= 0) begin
          v = pat(dev_a + 32'(j / 2));
          dq_i = (j % 2 == 0) ? v[15:8] : v[7:0];
        end else begin
          dq_i = 8'hEE;
        end
      end
    end
  end

  // ---------------- monitors ----------------
  logic [15:0] got [0:63];
  bit          gotl [0:63];
  int          gcnt = 0;
  bit          done_seen = 1'b0;
  int          got_clks = 0;
  int          hi_run = 0, last_gap = 0;
  int          lo_run = 0, last_setup = 0;
  bit          tog_seen = 1'b0;
  logic        prev_ck = 1'b0;
  int          err_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && gcnt < 64) begin
        got[gcnt]  = rd_data;
        gotl[gcnt] = rd_last;
        gcnt++;
      end
      if (txn_done) begin
        done_seen = 1'b1;
        got_clks  = int'(txn_clks);
      end
      if (req_err) err_cnt++;
      if (cs_n) begin
        hi_run++;
        lo_run   = 0;
        tog_seen = 1'b0;
      end else begin
        if (hi_run > 0) last_gap = hi_run;
        hi_run = 0;
        if (!tog_seen) begin
          if (bus_ck != prev_ck) begin
            tog_seen   = 1'b1;
            last_setup = lo_run;
          end else begin
            lo_run++;
          end
        end
      end
      prev_ck = bus_ck;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input int len);
    @(negedge clk);
    req_addr  = a;
    req_len   = LEN_W'(len);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_words(input int n);
    int t = 0;
    while ((gcnt < n || !done_seen) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_words(input logic [31:0] a, input int len, input int base, input string rq);
    int bad = 0;
    int lastbad = 0;
    for (int i = 0; i < len; i++) begin
      if (got[base + i] != pat(a + 32'(i))) bad++;
      if (gotl[base + i] != (i == len - 1)) lastbad++;
    end
    chk(bad == 0, rq, bad, 0);
    chk(lastbad == 0, "R6 last flag", lastbad, 0);
  endtask

  task automatic run_read(input logic [31:0] a, input int len, input int exp_clks, input string rq);
    gcnt = 0;
    done_seen = 1'b0;
    issue(a, len);
    wait_words(len);
    chk(gcnt == len, "R6 word count", gcnt, len);
    check_words(a, len, 0, rq);
    chk(got_clks == exp_clks, {rq, " R7 clock count"}, got_clks, exp_clks);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cs_n == 1'b1, "R8 reset cs_n", int'(cs_n), 1);
    chk(bus_ck == 1'b0 && bus_ck_n == 1'b1, "R8 reset bus_ck", int'(bus_ck), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R6 reset rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_random2();
    run_read(32'h0001_0000, 2, 14, "R4 aligned 2-word");
  endtask

  task automatic t_header();
    logic [31:0] a = 32'h00AB_CDE3;
    run_read(a, 2, 14, "R4 header read");
    chk(ca_rx[47:45] == 3'b101, "R3 type bits", int'(ca_rx[47:45]), 5);
    chk(ca_rx[15:3] == '0, "R3 reserved bits", int'(ca_rx[15:3]), 0);
    chk(dev_a == a, "R3 address split", int'(dev_a), int'(a));
  endtask

  task automatic t_off7_cross();
    run_read(32'h0001_0007, 16, LAT + 2 + 16 + 1, "R5 offset 7 cross");
  endtask

  task automatic t_offf_cross();
    run_read(32'h0002_000F, 4, LAT + 2 + 4 + 1, "R5 offset F cross");
  endtask

  task automatic t_off7_short();
    run_read(32'h0003_0007, 9, LAT + 2 + 9, "R5 offset 7 no cross");
  endtask

  task automatic t_off6();
    run_read(32'h0004_0006, 20, LAT + 2 + 20, "R5 offset 6");
  endtask

  task automatic t_zero_len();
    int cs_low = 0;
    int e0 = err_cnt;
    gcnt = 0;
    done_seen = 1'b0;
    issue(32'h0000_1234, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cs_n) cs_low++;
    end
    chk(err_cnt - e0 == 1, "R2 error pulse", err_cnt - e0, 1);
    chk(cs_low == 0, "R2 no chip select", cs_low, 0);
    chk(gcnt == 0 && !done_seen, "R2 no transaction", gcnt, 0);
    chk(req_ready == 1'b1, "R1 ready after reject", int'(req_ready), 1);
  endtask

  task automatic t_back2back();
    logic [31:0] a0 = 32'h0005_0010;
    logic [31:0] a1 = 32'h0006_0003;
    int t = 0;
    bit saw_busy = 1'b0;
    gcnt = 0;
    done_seen = 1'b0;
    issue(a0, 3);
    @(negedge clk);
    req_addr  = a1;
    req_len   = LEN_W'(5);
    req_valid = 1'b1;
    while (!req_ready && t < 3000) begin
      saw_busy = 1'b1;
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(saw_busy, "R1 ready low while busy", int'(saw_busy), 1);
    done_seen = 1'b0;
    wait_words(8);
    chk(gcnt == 8, "R6 back-to-back words", gcnt, 8);
    check_words(a0, 3, 0, "R6 first burst");
    check_words(a1, 5, 3, "R6 second burst");
    chk(last_gap >= CSHI, "R9 chip select high gap", last_gap, CSHI);
    chk(last_setup >= CSS, "R8 setup before clock", last_setup, CSS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_random2();
    t_header();
    t_off7_cross();
    t_offf_cross();
    t_off7_short();
    t_off6();
    t_zero_len();
    t_back2back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule